// File: doc/BRIEF.md
# Command Mailbox Register Interface

This block joins a processor bus to a command engine in FPGA fabric. The fabric posts a pending command by pulsing a strobe together with a command type, a locality and a buffer length. It can also flag that the host abandoned the running command. The processor sees the command through a 4 KiB memory-mapped window. The window holds a status word, three read-only command fields, a write-only acknowledge register and a 2 KiB shared data buffer.

While a command is pending, a level interrupt toward the processor stays high. The processor moves data through the shared buffer. The fabric reaches the same buffer through its own port. The processor then writes the acknowledge register. That write drops the interrupt and sends the fabric a completion pulse that clears itself.

The window starts at a base address given as a parameter (default 0xF000_0000). The register offsets are fixed, because software decodes them. Addresses inside the window that map to nothing read back as 0xBADFABAC.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, `cpu_irq` and `fab_done` are 0, and the status word reads 0.
- R2: A `fab_post` strobe marks a command pending. From the next cycle, `cpu_irq` is 1 and status bit 0 (pending) reads 1.
- R3: The command-type word (offset 0x004), locality word (0x008) and length word (0x00C) return the values latched at `fab_post`, zero-extended, while the command is pending. When no command is pending they read 0. All reserved status bits read 0.
- R4: A `fab_abort` strobe sets status bit 1 (aborted). A new `fab_post` clears it, unless `fab_abort` comes in the same cycle. An acknowledge also clears it.
- R5: A write of any data to the acknowledge register (offset 0x040) has these effects. It clears pending and aborted from the next cycle, which drops `cpu_irq`. It drives `fab_done` high for exactly 4 cycles from the next cycle, and status bit 2 mirrors `fab_done`. If `fab_post` comes in the same cycle as the acknowledge write, the new command stays pending.
- R6: A read of the acknowledge register returns 0.
- R7: Inside the window, a read of an offset below 0x800 that is not one of the five registers returns 0xBADFABAC, and a write to such an offset is dropped. Outside the window, reads return 0 and writes are dropped.
- R8: Writes to the status word and to the three command fields have no effect.
- R9: Offsets 0x800 to 0xFFF form the shared buffer (512 words). A processor write stores only the bytes whose `cpu_be` bit is 1. Read data appears on `cpu_rdata` one cycle after `cpu_re`.
- R10: The fabric port writes the same buffer with byte strobes (`fab_ram_addr` is the word index). `fab_ram_rdata` holds the word at `fab_ram_addr` one cycle later. Data written on either port is visible on the other.
- R11: If both ports write the same word in the same cycle, the processor write is stored and the whole fabric write to that word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_be | input | 4 | Processor byte strobes |
| cpu_we | input | 1 | Processor write enable |
| cpu_re | input | 1 | Processor read strobe |
| cpu_rdata | output | 32 | Processor read data, valid one cycle after `cpu_re` |
| cpu_irq | output | 1 | Level interrupt, high while a command is pending |
| fab_post | input | 1 | Strobe that posts a new command |
| fab_op | input | 8 | Command type |
| fab_loc | input | 4 | Command locality |
| fab_size | input | 12 | Command buffer length |
| fab_abort | input | 1 | Strobe that flags an aborted command |
| fab_done | output | 1 | Completion pulse, 4 cycles long |
| fab_ram_we | input | 1 | Fabric buffer write enable |
| fab_ram_addr | input | 9 | Fabric buffer word index |
| fab_ram_wdata | input | 32 | Fabric buffer write data |
| fab_ram_be | input | 4 | Fabric buffer byte strobes |
| fab_ram_rdata | output | 32 | Fabric buffer read data, one cycle after the address |

## Verification
All stimulus is driven on the falling edge, and results are sampled on a later falling edge.

Latencies the checks rely on:
- Processor read data, the fabric port's read word, `cpu_irq` after `fab_post`, and the status bits are due at the falling edge one cycle after the rising edge that captured the stimulus.
- `fab_done` must read high at the four falling edges after the acknowledge edge and low at the fifth. The bench counts those edges one at a time.
- For a write that must be ignored, the bench reads the affected register or buffer word back through the processor port right afterwards, so no other access can hide the result.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Region selected by a processor address
    typedef enum logic [2:0] {
        RG_STATUS,
        RG_OPTYPE,
        RG_LOCAL,
        RG_BUFLEN,
        RG_ACK,
        RG_RAM,
        RG_HOLE,
        RG_OUTSIDE
    } mbx_region_e;

    localparam logic [31:0] MBX_SENTINEL = 32'hBADF_ABAC;

    // Status word bit positions
    localparam int ST_PEND  = 0;
    localparam int ST_ABORT = 1;
    localparam int ST_DONE  = 2;

    // Register word indices inside the window (byte offset / 4)
    localparam int IDX_STATUS = 0;
    localparam int IDX_OPTYPE = 1;
    localparam int IDX_LOCAL  = 2;
    localparam int IDX_BUFLEN = 3;
    localparam int IDX_ACK    = 16;

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          WIN_AW = 12,
    parameter logic [31:0] BASE   = 32'hF000_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    output mbx_region_e         region,
    output logic [WIN_AW-4:0]   word_idx
);
    localparam int IDX_W = WIN_AW - 3;

    logic [WIN_AW-1:0] offset;
    logic              in_window;

    always_comb begin
        offset    = addr[WIN_AW-1:0];
        in_window = (addr[ADDR_W-1:WIN_AW] == BASE[ADDR_W-1:WIN_AW]);
        word_idx  = offset[WIN_AW-2:2];
        if (!in_window) begin
            region = RG_OUTSIDE;
        end else if (offset[WIN_AW-1]) begin
            region = RG_RAM;
        end else begin
            unique case (word_idx)
                IDX_W'(IDX_STATUS): region = RG_STATUS;
                IDX_W'(IDX_OPTYPE): region = RG_OPTYPE;
                IDX_W'(IDX_LOCAL):  region = RG_LOCAL;
                IDX_W'(IDX_BUFLEN): region = RG_BUFLEN;
                IDX_W'(IDX_ACK):    region = RG_ACK;
                default:            region = RG_HOLE;
            endcase
        end
    end

endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic [DW/8-1:0] a_be,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic [DW/8-1:0] b_be,
    output logic [DW-1:0] b_rdata
);
    localparam int WORDS = 1 << AW;
    localparam int NB    = DW / 8;

    logic same_word;
    assign same_word = a_we && (a_addr == b_addr);

    for (genvar lane = 0; lane < NB; lane++) begin : g_lane
        logic [7:0] store [WORDS];
        logic [7:0] a_rd_q;
        logic [7:0] b_rd_q;

        // Port A (processor) wins a shared word; port B is dropped there
        always_ff @(posedge clk) begin
            if (a_we && a_be[lane]) begin
                store[a_addr] <= a_wdata[lane*8 +: 8];
            end
            if (b_we && b_be[lane] && !same_word) begin
                store[b_addr] <= b_wdata[lane*8 +: 8];
            end
            if (a_re) begin
                a_rd_q <= store[a_addr];
            end
            b_rd_q <= store[b_addr];
        end

        assign a_rdata[lane*8 +: 8] = a_rd_q;
        assign b_rdata[lane*8 +: 8] = b_rd_q;
    end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int OP_W      = 8,
    parameter int LOC_W     = 4,
    parameter int SIZE_W    = 12,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mbx_region_e       region,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [31:0]       ram_rdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_irq,
    input  logic              fab_post,
    input  logic [OP_W-1:0]   fab_op,
    input  logic [LOC_W-1:0]  fab_loc,
    input  logic [SIZE_W-1:0] fab_size,
    input  logic              fab_abort,
    output logic              fab_done
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic              pend;
        logic              abort;
        logic [OP_W-1:0]   op;
        logic [LOC_W-1:0]  loc;
        logic [SIZE_W-1:0] size;
        logic [CNT_W-1:0]  cnt;
        logic              rd_ram;
        logic [31:0]       rd_reg;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  ack_wr;
    logic  done_now;
    logic [31:0] status_word;

    always_comb begin
        st_d        = st_q;
        ack_wr      = cpu_we && (region == RG_ACK);
        done_now    = (st_q.cnt != '0);
        status_word = '0;
        status_word[ST_PEND]  = st_q.pend;
        status_word[ST_ABORT] = st_q.abort;
        status_word[ST_DONE]  = done_now;

        if (ack_wr) begin
            st_d.pend  = 1'b0;
            st_d.abort = 1'b0;
            st_d.cnt   = CNT_W'(PULSE_LEN);
        end else if (done_now) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        if (fab_abort) begin
            st_d.abort = 1'b1;
        end

        if (fab_post) begin
            st_d.pend  = 1'b1;
            st_d.abort = fab_abort;
            st_d.op    = fab_op;
            st_d.loc   = fab_loc;
            st_d.size  = fab_size;
        end

        if (cpu_re) begin
            st_d.rd_ram = (region == RG_RAM);
            unique case (region)
                RG_STATUS: st_d.rd_reg = status_word;
                RG_OPTYPE: st_d.rd_reg = st_q.pend ? 32'(st_q.op)   : '0;
                RG_LOCAL:  st_d.rd_reg = st_q.pend ? 32'(st_q.loc)  : '0;
                RG_BUFLEN: st_d.rd_reg = st_q.pend ? 32'(st_q.size) : '0;
                RG_HOLE:   st_d.rd_reg = MBX_SENTINEL;
                default:   st_d.rd_reg = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata = st_q.rd_ram ? ram_rdata : st_q.rd_reg;
    assign cpu_irq   = st_q.pend;
    assign fab_done  = (st_q.cnt != '0);

    // R2: a posted command raises the interrupt on the next cycle
    p_post_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fab_post |=> cpu_irq);

    // R5: an acknowledge without a new post drops the interrupt
    p_ack_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && region == RG_ACK && !fab_post) |=> !cpu_irq);

    // R5: the completion pulse starts right after the acknowledge
    p_ack_starts_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && region == RG_ACK) |=> fab_done);

    // R5: the pulse never lasts a single cycle
    p_done_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fab_done) |=> fab_done);

    // R4: an abort strobe shows in the status state
    p_abort_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fab_abort |=> st_q.abort);

    // R8: writes to the read-only fields leave the command unchanged
    p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !fab_post && (region == RG_OPTYPE || region == RG_LOCAL ||
         region == RG_BUFLEN || region == RG_STATUS)) |=> $stable(st_q.op));

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'hF000_0000,
    parameter int          WIN_AW    = 12,
    parameter int          OP_W      = 8,
    parameter int          LOC_W     = 4,
    parameter int          SIZE_W    = 12,
    parameter int          PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    input  logic [3:0]        cpu_be,
    input  logic              cpu_we,
    input  logic              cpu_re,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_irq,
    input  logic              fab_post,
    input  logic [OP_W-1:0]   fab_op,
    input  logic [LOC_W-1:0]  fab_loc,
    input  logic [SIZE_W-1:0] fab_size,
    input  logic              fab_abort,
    output logic              fab_done,
    input  logic              fab_ram_we,
    input  logic [WIN_AW-4:0] fab_ram_addr,
    input  logic [31:0]       fab_ram_wdata,
    input  logic [3:0]        fab_ram_be,
    output logic [31:0]       fab_ram_rdata
);
    localparam int RAM_AW = WIN_AW - 3;

    mbx_region_e       region;
    logic [RAM_AW-1:0] word_idx;
    logic [31:0]       ram_rdata;
    logic              ram_we;
    logic              ram_re;

    assign ram_we = cpu_we && (region == RG_RAM);
    assign ram_re = cpu_re && (region == RG_RAM);

    mbx_addr_dec #(
        .ADDR_W (32),
        .WIN_AW (WIN_AW),
        .BASE   (BASE)
    ) u_dec (
        .addr     (cpu_addr),
        .region   (region),
        .word_idx (word_idx)
    );

    mbx_dpram #(
        .AW (RAM_AW),
        .DW (32)
    ) u_ram (
        .clk     (clk),
        .a_we    (ram_we),
        .a_re    (ram_re),
        .a_addr  (word_idx),
        .a_wdata (cpu_wdata),
        .a_be    (cpu_be),
        .a_rdata (ram_rdata),
        .b_we    (fab_ram_we),
        .b_addr  (fab_ram_addr),
        .b_wdata (fab_ram_wdata),
        .b_be    (fab_ram_be),
        .b_rdata (fab_ram_rdata)
    );

    mbx_ctrl #(
        .OP_W      (OP_W),
        .LOC_W     (LOC_W),
        .SIZE_W    (SIZE_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .region    (region),
        .cpu_we    (cpu_we),
        .cpu_re    (cpu_re),
        .ram_rdata (ram_rdata),
        .cpu_rdata (cpu_rdata),
        .cpu_irq   (cpu_irq),
        .fab_post  (fab_post),
        .fab_op    (fab_op),
        .fab_loc   (fab_loc),
        .fab_size  (fab_size),
        .fab_abort (fab_abort),
        .fab_done  (fab_done)
    );

    // R7: a hole inside the window reads as the sentinel
    p_hole_sentinel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && region == RG_HOLE) |=> (cpu_rdata == MBX_SENTINEL));

    // R7: addresses outside the window read as zero
    p_outside_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && region == RG_OUTSIDE) |=> (cpu_rdata == 32'h0));

    // R6: the acknowledge register reads as zero
    p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && region == RG_ACK) |=> (cpu_rdata == 32'h0));

endmodule

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;

    localparam logic [31:0] BASE = 32'hF000_0000;
    localparam logic [31:0] RAMB = BASE + 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_we = 1'b0, cpu_re = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cpu_irq;
    logic        fab_post = 1'b0, fab_abort = 1'b0;
    logic [7:0]  fab_op = '0;
    logic [3:0]  fab_loc = '0;
    logic [11:0] fab_size = '0;
    logic        fab_done;
    logic        fab_ram_we = 1'b0;
    logic [8:0]  fab_ram_addr = '0;
    logic [31:0] fab_ram_wdata = '0;
    logic [3:0]  fab_ram_be = '0;
    logic [31:0] fab_ram_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] shadow [16];

    always #10 clk = ~clk;

    cmd_mailbox u0 (
        .clk (clk), .rst_n (rst_n),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_be (cpu_be),
        .cpu_we (cpu_we), .cpu_re (cpu_re), .cpu_rdata (cpu_rdata),
        .cpu_irq (cpu_irq),
        .fab_post (fab_post), .fab_op (fab_op), .fab_loc (fab_loc),
        .fab_size (fab_size), .fab_abort (fab_abort), .fab_done (fab_done),
        .fab_ram_we (fab_ram_we), .fab_ram_addr (fab_ram_addr),
        .fab_ram_wdata (fab_ram_wdata), .fab_ram_be (fab_ram_be),
        .fab_ram_rdata (fab_ram_rdata)
    );

    function automatic logic [31:0] merge(logic [31:0] old_w, logic [31:0] new_w,
                                          logic [3:0] be);
        logic [31:0] r = old_w;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] status_exp(bit pend, bit abort, bit done);
        return {29'b0, done, abort, pend};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_wr(logic [31:0] a, logic [31:0] d, logic [3:0] be);
        cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_we = 1'b1;
        tick();
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(logic [31:0] a, output logic [31:0] d);
        cpu_addr = a; cpu_re = 1'b1;
        tick();
        cpu_re = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic fab_wr(logic [8:0] a, logic [31:0] d, logic [3:0] be);
        fab_ram_addr = a; fab_ram_wdata = d; fab_ram_be = be; fab_ram_we = 1'b1;
        tick();
        fab_ram_we = 1'b0;
    endtask

    task automatic fab_rd(logic [8:0] a, output logic [31:0] d);
        fab_ram_addr = a;
        tick();
        d = fab_ram_rdata;
    endtask

    task automatic post_cmd(logic [7:0] op, logic [3:0] loc, logic [11:0] sz);
        fab_op = op; fab_loc = loc; fab_size = sz; fab_post = 1'b1;
        tick();
        fab_post = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", 32'(cpu_irq), 32'h0);
        chk("R1 done", 32'(fab_done), 32'h0);
        cpu_rd(BASE + 32'h000, rd); chk("R1 status", rd, 32'h0);
        cpu_rd(BASE + 32'h004, rd); chk("R3 op idle", rd, 32'h0);

        // R2 / R3: post a command
        post_cmd(8'h5A, 4'h3, 12'h123);
        chk("R2 irq", 32'(cpu_irq), 32'h1);
        cpu_rd(BASE + 32'h000, rd); chk("R2 status", rd, status_exp(1, 0, 0));
        cpu_rd(BASE + 32'h004, rd); chk("R3 op", rd, 32'h5A);
        cpu_rd(BASE + 32'h008, rd); chk("R3 loc", rd, 32'h3);
        cpu_rd(BASE + 32'h00C, rd); chk("R3 size", rd, 32'h123);

        // R8: writes to read-only words are ignored
        cpu_wr(BASE + 32'h004, 32'hFFFF_FFFF, 4'hF);
        cpu_wr(BASE + 32'h000, 32'hFFFF_FFFF, 4'hF);
        cpu_wr(BASE + 32'h00C, 32'hFFFF_FFFF, 4'hF);
        cpu_rd(BASE + 32'h004, rd); chk("R8 op", rd, 32'h5A);
        cpu_rd(BASE + 32'h00C, rd); chk("R8 size", rd, 32'h123);
        cpu_rd(BASE + 32'h000, rd); chk("R8 status", rd, status_exp(1, 0, 0));

        // R4: abort flag
        fab_abort = 1'b1; tick(); fab_abort = 1'b0;
        cpu_rd(BASE + 32'h000, rd); chk("R4 abort", rd, status_exp(1, 1, 0));

        // R5: acknowledge and completion pulse
        cpu_wr(BASE + 32'h040, 32'hDEAD_BEEF, 4'hF);
        chk("R5 irq low", 32'(cpu_irq), 32'h0);
        for (int i = 0; i < 4; i++) begin
            chk("R5 done high", 32'(fab_done), 32'h1);
            tick();
        end
        chk("R5 done low", 32'(fab_done), 32'h0);
        cpu_rd(BASE + 32'h000, rd); chk("R4 abort cleared", rd, 32'h0);
        cpu_rd(BASE + 32'h004, rd); chk("R3 op after ack", rd, 32'h0);

        // R5: status mirrors the pulse
        post_cmd(8'h11, 4'h0, 12'h010);
        cpu_wr(BASE + 32'h040, 32'h0, 4'h0);
        cpu_rd(BASE + 32'h000, rd); chk("R5 status done", rd, status_exp(0, 0, 1));
        repeat (5) tick();

        // R4: new post clears a stale abort
        post_cmd(8'h22, 4'h1, 12'h020);
        fab_abort = 1'b1; tick(); fab_abort = 1'b0;
        post_cmd(8'h23, 4'h1, 12'h020);
        cpu_rd(BASE + 32'h000, rd); chk("R4 post clears abort", rd, status_exp(1, 0, 0));

        // R5: post in the same cycle as the acknowledge keeps the command
        fab_op = 8'h77; fab_loc = 4'h2; fab_size = 12'h7FF; fab_post = 1'b1;
        cpu_addr = BASE + 32'h040; cpu_we = 1'b1; cpu_be = 4'hF;
        tick();
        fab_post = 1'b0; cpu_we = 1'b0;
        chk("R5 post wins irq", 32'(cpu_irq), 32'h1);
        chk("R5 post wins done", 32'(fab_done), 32'h1);
        cpu_rd(BASE + 32'h004, rd); chk("R5 post wins op", rd, 32'h77);
        repeat (5) tick();

        // R6: acknowledge reads as zero
        cpu_rd(BASE + 32'h040, rd); chk("R6 ack read", rd, 32'h0);

        // R7: holes and outside addresses
        cpu_rd(BASE + 32'h010, rd); chk("R7 hole 0x010", rd, 32'hBADF_ABAC);
        cpu_rd(BASE + 32'h7FC, rd); chk("R7 hole 0x7FC", rd, 32'hBADF_ABAC);
        cpu_rd(BASE + 32'h044, rd); chk("R7 hole 0x044", rd, 32'hBADF_ABAC);
        cpu_rd(32'h1000_0000, rd);  chk("R7 outside", rd, 32'h0);
        cpu_wr(RAMB, 32'hCAFE_F00D, 4'hF);
        cpu_wr(32'hE000_0800, 32'h1234_5678, 4'hF);
        cpu_wr(BASE + 32'h010, 32'h1234_5678, 4'hF);
        cpu_rd(RAMB, rd); chk("R7 outside write dropped", rd, 32'hCAFE_F00D);
        cpu_rd(BASE + 32'h010, rd); chk("R7 hole write dropped", rd, 32'hBADF_ABAC);
        cpu_rd(BASE + 32'h004, rd); chk("R7 regs untouched", rd, 32'h77);

        // R9: byte strobes on the processor port
        cpu_wr(RAMB + 32'h4, 32'h0000_0000, 4'hF);
        cpu_wr(RAMB + 32'h4, 32'hAABB_CCDD, 4'b0101);
        cpu_rd(RAMB + 32'h4, rd); chk("R9 byte strobe", rd, 32'h00BB_00DD);
        cpu_rd(RAMB + 32'h7FC, rd);
        cpu_wr(RAMB + 32'h7FC, 32'h0F0F_0F0F, 4'hF);
        cpu_rd(RAMB + 32'h7FC, rd); chk("R9 last word", rd, 32'h0F0F_0F0F);

        // R10: cross-port visibility
        fab_rd(9'd1, rd); chk("R10 fabric sees cpu", rd, 32'h00BB_00DD);
        fab_wr(9'd2, 32'h1111_2222, 4'hF);
        fab_wr(9'd2, 32'h9999_8888, 4'b1000);
        cpu_rd(RAMB + 32'h8, rd); chk("R10 cpu sees fabric", rd, 32'h9911_2222);

        // R11: simultaneous write to one word
        cpu_addr = RAMB + 32'hC; cpu_wdata = 32'hAAAA_AAAA; cpu_be = 4'b0001; cpu_we = 1'b1;
        fab_ram_addr = 9'd3; fab_ram_wdata = 32'h5555_5555; fab_ram_be = 4'hF; fab_ram_we = 1'b1;
        cpu_wr(RAMB + 32'h10, 32'h0, 4'hF);
        fab_ram_we = 1'b0;
        cpu_wr(RAMB + 32'hC, 32'h0, 4'hF);
        cpu_addr = RAMB + 32'hC; cpu_wdata = 32'h1234_5678; cpu_be = 4'hF; cpu_we = 1'b1;
        fab_ram_addr = 9'd3; fab_ram_wdata = 32'h5555_5555; fab_ram_be = 4'hF; fab_ram_we = 1'b1;
        tick();
        cpu_we = 1'b0; fab_ram_we = 1'b0;
        cpu_rd(RAMB + 32'hC, rd); chk("R11 cpu wins", rd, 32'h1234_5678);

        // R9 / R10 / R11: random mix on 16 words
        for (int w = 0; w < 16; w++) begin
            shadow[w] = $urandom;
            cpu_wr(RAMB + 32'(w * 4), shadow[w], 4'hF);
        end
        for (int it = 0; it < 400; it++) begin
            int          kind = $urandom_range(0, 4);
            logic [3:0]  w    = 4'($urandom);
            logic [3:0]  w2   = 4'($urandom);
            logic [31:0] d    = $urandom;
            logic [31:0] d2   = $urandom;
            logic [3:0]  be   = 4'($urandom);
            logic [3:0]  be2  = 4'($urandom);
            case (kind)
                0: begin
                    cpu_wr(RAMB + 32'(w) * 4, d, be);
                    shadow[w] = merge(shadow[w], d, be);
                end
                1: begin
                    fab_wr(9'(w), d, be);
                    shadow[w] = merge(shadow[w], d, be);
                end
                2: begin
                    cpu_rd(RAMB + 32'(w) * 4, rd);
                    chk("R9 random cpu read", rd, shadow[w]);
                end
                3: begin
                    fab_rd(9'(w), rd);
                    chk("R10 random fabric read", rd, shadow[w]);
                end
                default: begin
                    cpu_addr = RAMB + 32'(w) * 4; cpu_wdata = d; cpu_be = be; cpu_we = 1'b1;
                    fab_ram_addr = 9'(w2); fab_ram_wdata = d2; fab_ram_be = be2; fab_ram_we = 1'b1;
                    tick();
                    cpu_we = 1'b0; fab_ram_we = 1'b0;
                    shadow[w] = merge(shadow[w], d, be);
                    if (w2 != w) shadow[w2] = merge(shadow[w2], d2, be2);
                    cpu_rd(RAMB + 32'(w2) * 4, rd);
                    chk("R11 random dual write", rd, shadow[w2]);
                end
            endcase
        end

        finish_run();
    end

endmodule